// File: doc/BRIEF.md
# Button-Driven Up/Down Counter with Switch Load

This block keeps a 16-bit count that moves by one step only on cycles where a slow count-enable tick is high. Two push-button levels, already debounced elsewhere, steer it through a small control state machine. A press of the direction button reverses the counting sense. A press of the set button copies an 8-bit switch value into the count, with the upper byte cleared. The press can come at any moment, and the current direction is kept.

The control machine is a Moore machine with four states. It keeps the direction and whether the direction button is still held. A separate rising-edge detector turns each press of the set button into a single-cycle load strobe. The load does not wait for the tick. When a load and a tick fall on the same cycle, the load wins. The outputs give the count, the current direction and the load strobe, so a display path or a parent controller can follow the block.

Top module: `updn_load_counter`

## Requirements
- R1: While rst_ni is low and at the first clock edge after it, count_o is 0x0000, dir_down_o is 0 (counting up) and load_o is 0.
- R2: When tick_i is 1, load_o is 0 and dir_down_o is 0 at a clock edge, count_o increases by one at that edge.
- R3: When tick_i is 1, load_o is 0 and dir_down_o is 1 at a clock edge, count_o decreases by one at that edge.
- R4: When tick_i is 0 and load_o is 0 at a clock edge, count_o keeps its value.
- R5: Counting up from 0xFFFF gives 0x0000.
- R6: Counting down from 0x0000 gives 0xFFFF.
- R7: A 0-to-1 change of dir_btn_i, seen at a clock edge, inverts dir_down_o at that edge. Holding the button high inverts it only once. dir_down_o never changes at an edge where dir_btn_i is 0.
- R8: A 0-to-1 change of set_btn_i, seen at a clock edge, raises load_o for exactly one cycle. At the edge that ends this strobe, count_o takes {8'h00, sw_i}, using the value of sw_i present at that edge.
- R9: If tick_i is 1 in the cycle where load_o is 1, the loaded switch value wins and no step is applied in that cycle.
- R10: A load leaves dir_down_o unchanged.
- R11: If both buttons rise at the same edge, the direction inverts at that edge and the load follows at the next edge. Later ticks count in the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable pulse, one cycle wide |
| sw_i | input | 8 | Switch value for the load |
| dir_btn_i | input | 1 | Debounced direction button level |
| set_btn_i | input | 1 | Debounced load button level |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 when counting down, 0 when counting up |
| load_o | output | 1 | One-cycle strobe that marks a pending load |

## Verification
If the control state holds the wrong direction, the error shows on dir_down_o at once. It also turns the next tick into a step of the wrong sign. If the machine has lost track of whether the direction button is held, a long press toggles a second time. That extra flip shows on dir_down_o one edge later. A faulty set-button edge detector gives a strobe that lasts too long or never comes. A faulty load path leaves the wrong value on count_o one cycle after the strobe. The reference model is compared on every cycle, so each of these errors is caught within one or two clocks of its cause.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // bit 1 = direction (1: down), bit 0 = direction button still held
  typedef enum logic [1:0] {
    ST_UP_IDLE = 2'b00,
    ST_UP_HELD = 2'b01,
    ST_DN_IDLE = 2'b10,
    ST_DN_HELD = 2'b11
  } ctl_state_e;

  function automatic logic state_is_down(ctl_state_e s);
    return (s == ST_DN_IDLE) || (s == ST_DN_HELD);
  endfunction

endpackage

// File: rtl/updn_edge_det.sv
module updn_edge_det #(
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/updn_ctrl_fsm.sv
module updn_ctrl_fsm
  import updn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_btn_i,
  input  logic set_btn_i,
  output logic dir_down_o,
  output logic load_o
);

  ctl_state_e state_q, state_d;
  logic       set_rise;
  logic       load_q;

  updn_edge_det #(.N(1)) u_set_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (set_btn_i),
    .rise_o (set_rise)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UP_IDLE: if (dir_btn_i)  state_d = ST_DN_HELD;
      ST_UP_HELD: if (!dir_btn_i) state_d = ST_UP_IDLE;
      ST_DN_IDLE: if (dir_btn_i)  state_d = ST_UP_HELD;
      ST_DN_HELD: if (!dir_btn_i) state_d = ST_DN_IDLE;
      default:                    state_d = ST_UP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UP_IDLE;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= set_rise;
    end
  end

  assign dir_down_o = state_is_down(state_q);
  assign load_o     = load_q;

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LD_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             load_i,
  input  logic [LD_W-1:0]  ld_val_i,
  output logic [CNT_W-1:0] count_o
);

  localparam int unsigned PAD_W = CNT_W - LD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, ld_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ld_ext = {{PAD_W{1'b0}}, ld_val_i};
    end else begin : g_nopad
      assign ld_ext = ld_val_i[CNT_W-1:0];
    end
  endgenerate

  // load outranks a tick in the same cycle
  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = ld_ext;
    else if (step_i) cnt_d = down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/updn_load_counter.sv
module updn_load_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SW_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SW_W-1:0]  sw_i,
  input  logic             dir_btn_i,
  input  logic             set_btn_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             load_o
);

  logic dir_down, load;

  updn_ctrl_fsm u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_btn_i  (dir_btn_i),
    .set_btn_i  (set_btn_i),
    .dir_down_o (dir_down),
    .load_o     (load)
  );

  updn_count_core #(.CNT_W(CNT_W), .LD_W(SW_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (tick_i),
    .down_i   (dir_down),
    .load_i   (load),
    .ld_val_i (sw_i),
    .count_o  (count_o)
  );

  assign dir_down_o = dir_down;
  assign load_o     = load;

endmodule

// File: rtl/updn_load_counter_chk.sv
module updn_load_counter_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SW_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [SW_W-1:0]  sw_i,
  input logic             dir_btn_i,
  input logic             set_btn_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o,
  input logic             load_o
);

  logic unused_ok;
  assign unused_ok = set_btn_i;

  // R2, R5
  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_o && !dir_down_o) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  // R3, R6
  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_o && dir_down_o) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_o) |=> $stable(count_o));

  // R7
  a_r7_dir_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_btn_i |=> $stable(dir_down_o));

  // R8, R9
  a_r8_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (count_o == CNT_W'($past(sw_i))));

  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

endmodule

bind updn_load_counter updn_load_counter_chk #(.CNT_W(CNT_W), .SW_W(SW_W)) u_chk (.*);

// File: tb/tb_updn_load_counter.sv
`timescale 1ns/1ps
module tb_updn_load_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  sw = 8'h00;
  logic        dir_btn = 1'b0;
  logic        set_btn = 1'b0;
  logic [15:0] count;
  logic        dir_down;
  logic        load;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  updn_load_counter dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .sw_i       (sw),
    .dir_btn_i  (dir_btn),
    .set_btn_i  (set_btn),
    .count_o    (count),
    .dir_down_o (dir_down),
    .load_o     (load)
  );

  // behavioural reference
  int    m_cnt;
  bit    m_down, m_load, m_dir_prev, m_set_prev;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_down <= 0; m_load <= 0;
      m_dir_prev <= 0; m_set_prev <= 0; m_tag <= "R1";
    end else begin
      if (m_load) begin
        m_cnt <= int'(sw);
        m_tag <= tick ? "R9" : "R8";
      end else if (tick) begin
        m_cnt <= m_down ? (m_cnt + 65535) % 65536 : (m_cnt + 1) % 65536;
        if (!m_down && m_cnt == 65535)  m_tag <= "R5";
        else if (m_down && m_cnt == 0)  m_tag <= "R6";
        else                            m_tag <= m_down ? "R3" : "R2";
      end else begin
        m_tag <= "R4";
      end
      m_load     <= set_btn && !m_set_prev;
      m_set_prev <= set_btn;
      if (dir_btn && !m_dir_prev) m_down <= !m_down;
      m_dir_prev <= dir_btn;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_tag, int'(count), m_cnt);
      chk("R7", int'(dir_down), int'(m_down));
      chk("R8", int'(load), int'(m_load));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1", int'(count), 0);
    chk("R1", int'(dir_down), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", int'(count), 0);
    chk("R1", int'(dir_down), 0);
    chk("R1", int'(load), 0);

    tick = 1; cyc(5); tick = 0;
    chk("R2", int'(count), 5);
    cyc(3);
    chk("R4", int'(count), 5);

    dir_btn = 1; cyc(1);
    chk("R7", int'(dir_down), 1);
    cyc(4);
    chk("R7", int'(dir_down), 1);      // held: toggled once
    dir_btn = 0; cyc(1);

    tick = 1; cyc(5);
    chk("R3", int'(count), 0);
    cyc(1); tick = 0;
    chk("R6", int'(count), 16'hFFFF);

    dir_btn = 1; cyc(1); dir_btn = 0; cyc(1);
    chk("R7", int'(dir_down), 0);
    tick = 1; cyc(1); tick = 0;
    chk("R5", int'(count), 0);

    dir_btn = 1; cyc(1); dir_btn = 0; cyc(1);
    sw = 8'hA5; set_btn = 1; cyc(1);
    chk("R8", int'(load), 1);
    tick = 1; cyc(1);
    chk("R9", int'(count), 16'h00A5);
    chk("R10", int'(dir_down), 1);
    chk("R8", int'(load), 0);
    cyc(1); tick = 0;
    chk("R3", int'(count), 16'h00A4);
    set_btn = 0; cyc(1);

    sw = 8'h3C; set_btn = 1; dir_btn = 1; cyc(1);
    chk("R11", int'(load), 1);
    chk("R11", int'(dir_down), 0);
    cyc(1);
    chk("R11", int'(count), 16'h003C);
    set_btn = 0; dir_btn = 0; tick = 1; cyc(1); tick = 0;
    chk("R11", int'(count), 16'h003D);

    for (int i = 0; i < 4000; i++) begin
      tick    = ($urandom_range(3) == 0);
      set_btn = ($urandom_range(15) == 0) ? !set_btn : set_btn;
      dir_btn = ($urandom_range(11) == 0) ? !dir_btn : dir_btn;
      sw      = 8'($urandom);
      cyc(1);
    end
    tick = 0; set_btn = 0; dir_btn = 0;
    cyc(2);
    finish_run();
  end

endmodule